// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

This block is a watchdog built around a free-running binary counter. The counter restarts on each expiry. Software works it through a small register write port with two registers. The mode register holds an enable bit, a two-bit period selector and a reset-connect bit, and it can be read back at all times. The command register is write-only, and it acts only on two key values.

Writing the clear key restarts the counter from zero, so healthy firmware writes it periodically. If the counter reaches the selected period first, the block raises a one-clock timeout pulse. When the reset-connect bit is set, it raises a one-clock reset request in the same cycle.

The timer cannot be stopped by a single stray write. Stopping it needs three things in this order: the clear key written at least once, the enable bit written to 0, and then the disable key written. Writing the enable bit back to 1 restarts the timer at once.

Top module: `kwdt_top`

## Requirements
- R1: While reset is held and right after it, the mode read-back is 0x01 (enable=1, period=00, reset-connect=0), the timer is running, and both outputs are low.
- R2: Register writes use `wr_addr_i` 0 for the mode register and 1 for the command register. The mode layout is: bit 0 enable, bits 2:1 period select, bit 3 reset-connect. Bits 7:4 read as 0.
- R3: Period code k (0..3) selects a period of 2^(PER_BASE_LOG2 + PER_STEP_LOG2*k) clocks, which is 2^15, 2^17, 2^19 and 2^21 with the defaults. Once running, the first timeout pulse comes exactly one period after the counter starts from zero, and further pulses follow every period.
- R4: The timeout pulse lasts one clock. The reset request pulses in the same clock only when reset-connect is 1, and it stays low otherwise.
- R5: Writing 0x4E to the command register restarts the counter from zero and arms the disable key. If this write lands in the cycle where an expiry would occur, that expiry's pulse is suppressed, and the next pulse comes one full period after the write.
- R6: Writing 0xB1 to the command register stops the timer only when the enable bit is 0 and the key is armed. Stopping clears the arm. Writing 0xB1 while enable is 1, or while not armed, has no effect.
- R7: Command values other than 0x4E and 0xB1 have no effect.
- R8: Writing the mode register with enable=1 while the timer is stopped restarts it at once. The counter starts from zero.
- R9: While the timer is stopped, no timeout pulse and no reset request are produced.
- R10: The period select and reset-connect bits take written values only while the timer is stopped, and writes to them while it runs are ignored. The enable bit is writable at all times, and clearing it alone does not stop the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 1 | Register select: 0 mode, 1 command |
| wr_data_i | input | 8 | Write data |
| mode_rdata_o | output | 8 | Mode register read-back |
| tmo_irq_o | output | 1 | One-clock timeout pulse |
| rst_req_o | output | 1 | One-clock reset request |

## Verification
Two functions can fall in the same cycle: a clear-key write and the counter reaching its terminal value. The bench provokes this by counting clocks from reset release and landing the 0x4E write on exactly the expiry edge. It then expects no pulse in that cycle and the next pulse one full period later. A second coincidence is a stopping 0xB1 write on an expiry edge. This is covered by the rule that a stopped timer never pulses, and it is judged by counting pulses over a window longer than the period after each write.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int unsigned NUM_PERIODS = 4;
    localparam int unsigned PSEL_W      = $clog2(NUM_PERIODS);

    localparam logic [7:0] KEY_CLEAR   = 8'h4E;
    localparam logic [7:0] KEY_DISABLE = 8'hB1;

    localparam int unsigned MODE_EN_BIT  = 0;
    localparam int unsigned MODE_PER_LSB = 1;
    localparam int unsigned MODE_RC_BIT  = 3;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_CMD  = 1'b1;

    typedef struct packed {
        logic              en;
        logic [PSEL_W-1:0] per;
        logic              rc;
        logic              running;
        logic              armed;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{
        en:      1'b1,
        per:     '0,
        rc:      1'b0,
        running: 1'b1,
        armed:   1'b0
    };

endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec
    import kwdt_pkg::*;
(
    input  logic       wr_en_i,
    input  logic       wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic       mode_wr_o,
    output logic       key_clear_o,
    output logic       key_disable_o
);

    logic cmd_wr;

    always_comb begin
        cmd_wr        = wr_en_i && (wr_addr_i == ADDR_CMD);
        mode_wr_o     = wr_en_i && (wr_addr_i == ADDR_MODE);
        key_clear_o   = cmd_wr && (wr_data_i == KEY_CLEAR);
        key_disable_o = cmd_wr && (wr_data_i == KEY_DISABLE);
    end

endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_i,
    input  logic [7:0]        wdata_i,
    input  logic              key_clear_i,
    input  logic              key_disable_i,
    output logic              running_o,
    output logic              stop_now_o,
    output logic [PSEL_W-1:0] per_o,
    output logic              rc_o,
    output logic [7:0]        mode_rdata_o
);

    ctrl_state_t s_d, s_q;
    logic        stop_d;

    always_comb begin
        s_d    = s_q;
        stop_d = 1'b0;

        if (mode_wr_i) begin
            s_d.en = wdata_i[MODE_EN_BIT];
            if (!s_q.running) begin
                s_d.per = wdata_i[MODE_PER_LSB +: PSEL_W];
                s_d.rc  = wdata_i[MODE_RC_BIT];
            end
            if (wdata_i[MODE_EN_BIT]) begin
                s_d.running = 1'b1;
            end
        end

        if (key_clear_i) begin
            s_d.armed = 1'b1;
        end

        if (key_disable_i && s_q.running && !s_q.en && s_q.armed) begin
            stop_d      = 1'b1;
            s_d.running = 1'b0;
            s_d.armed   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CTRL_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        running_o    = s_q.running;
        stop_now_o   = stop_d;
        per_o        = s_q.per;
        rc_o         = s_q.rc;
        mode_rdata_o = '0;
        mode_rdata_o[MODE_EN_BIT]               = s_q.en;
        mode_rdata_o[MODE_PER_LSB +: PSEL_W]    = s_q.per;
        mode_rdata_o[MODE_RC_BIT]               = s_q.rc;
    end

    // R6
    stop_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.running) |-> $past(s_q.armed && !s_q.en && key_disable_i));

    // R8
    start_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.running) |-> s_q.en);

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.running && $past(s_q.running)) |-> ($stable(s_q.per) && $stable(s_q.rc)));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int unsigned PER_BASE_LOG2 = 15,
    parameter int unsigned PER_STEP_LOG2 = 2,
    localparam int unsigned CW = PER_BASE_LOG2 + PER_STEP_LOG2 * (NUM_PERIODS - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic              stop_i,
    input  logic [PSEL_W-1:0] per_i,
    output logic              tmo_o
);

    logic [CW-1:0] limit [NUM_PERIODS];

    for (genvar i = 0; i < NUM_PERIODS; i++) begin : g_limit
        assign limit[i] = CW'((64'd1 << (PER_BASE_LOG2 + PER_STEP_LOG2 * i)) - 64'd1);
    end

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tmo;
    } cnt_state_t;

    cnt_state_t c_d, c_q;
    logic       hit;

    always_comb begin
        hit     = (c_q.cnt == limit[per_i]);
        c_d     = c_q;
        c_d.tmo = 1'b0;
        if (!run_i || stop_i) begin
            c_d.cnt = '0;
        end else if (clear_i) begin
            c_d.cnt = '0;
        end else if (hit) begin
            c_d.cnt = '0;
            c_d.tmo = 1'b1;
        end else begin
            c_d.cnt = c_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign tmo_o = c_q.tmo;

    // R4
    tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.tmo |=> !c_q.tmo);

    // R9
    held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (c_q.cnt == '0));

    // R3
    within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (c_q.cnt <= limit[per_i]));

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && clear_i) |=> (!c_q.tmo && c_q.cnt == '0));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int unsigned PER_BASE_LOG2 = 15,
    parameter int unsigned PER_STEP_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic       wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] mode_rdata_o,
    output logic       tmo_irq_o,
    output logic       rst_req_o
);

    logic              mode_wr;
    logic              key_clear;
    logic              key_disable;
    logic              running;
    logic              stop_now;
    logic [PSEL_W-1:0] per;
    logic              rc;
    logic              tmo;

    kwdt_keydec u_keydec (
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .mode_wr_o     (mode_wr),
        .key_clear_o   (key_clear),
        .key_disable_o (key_disable)
    );

    kwdt_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_wr_i     (mode_wr),
        .wdata_i       (wr_data_i),
        .key_clear_i   (key_clear),
        .key_disable_i (key_disable),
        .running_o     (running),
        .stop_now_o    (stop_now),
        .per_o         (per),
        .rc_o          (rc),
        .mode_rdata_o  (mode_rdata_o)
    );

    kwdt_counter #(
        .PER_BASE_LOG2 (PER_BASE_LOG2),
        .PER_STEP_LOG2 (PER_STEP_LOG2)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running),
        .clear_i (key_clear),
        .stop_i  (stop_now),
        .per_i   (per),
        .tmo_o   (tmo)
    );

    assign tmo_irq_o = tmo;
    assign rst_req_o = tmo && rc;

    // R9
    quiet_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!tmo_irq_o && !rst_req_o));

    // R4
    rst_follows_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (tmo_irq_o && mode_rdata_o[MODE_RC_BIT]));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rdata_o[7:4] == 4'h0);

endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 4;
    localparam int STEP = 2;
    localparam int NVEC = 12;

    // {addr, data[7:0], expected mode[7:0], expected running}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 8'h4E, 8'h01, 1'b1},  // R5 arm
        {1'b0, 8'h0A, 8'h00, 1'b1},  // R10 cfg ignored, en cleared, still runs
        {1'b1, 8'h55, 8'h00, 1'b1},  // R7 stray value
        {1'b1, 8'hB1, 8'h00, 1'b0},  // R6 stops
        {1'b0, 8'h0A, 8'h0A, 1'b0},  // R10 cfg taken while stopped
        {1'b0, 8'h0B, 8'h0B, 1'b1},  // R8 restart
        {1'b1, 8'hB1, 8'h0B, 1'b1},  // R6 key with en=1
        {1'b0, 8'h0A, 8'h0A, 1'b1},  // R10 en clear alone
        {1'b1, 8'hB1, 8'h0A, 1'b1},  // R6 key not armed
        {1'b1, 8'h4E, 8'h0A, 1'b1},  // R5 arm again
        {1'b1, 8'hB1, 8'h0A, 1'b0},  // R6 stops
        {1'b0, 8'h01, 8'h01, 1'b1}   // R8 restart, period 00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] mode_rdata;
    logic       tmo_irq;
    logic       rst_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    kwdt_top #(.PER_BASE_LOG2(BASE), .PER_STEP_LOG2(STEP)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .mode_rdata_o (mode_rdata),
        .tmo_irq_o    (tmo_irq),
        .rst_req_o    (rst_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int per_len(input logic [1:0] sel);
        return 1 << (BASE + STEP * int'(sel));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_now(input logic a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(mode_rdata == 8'h01, "R1 mode in reset", mode_rdata, 8'h01);
        check(!tmo_irq && !rst_req, "R1 outputs in reset", {tmo_irq, rst_req}, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int t_seen;
        int r_seen;
        int win;
        int k;

        // R1 / R3: exact first expiry
        do_reset();
        for (int i = 1; i <= 17; i++) begin
            @(negedge clk);
            if (i == 1) check(mode_rdata == 8'h01, "R1 mode after reset", mode_rdata, 8'h01);
            if (i == 15) check(tmo_irq == 1'b0, "R3 no pulse before period", tmo_irq, 0);
            if (i == 16) begin
                check(tmo_irq == 1'b1, "R3 pulse at period", tmo_irq, 1);
                check(rst_req == 1'b0, "R4 no reset with rc=0", rst_req, 0);
            end
            if (i == 17) check(tmo_irq == 1'b0, "R4 pulse one clock", tmo_irq, 0);
        end

        // R5: clear key lands on the expiry edge
        do_reset();
        repeat (15) @(negedge clk);
        wr_now(1'b1, 8'h4E);
        check(tmo_irq == 1'b0, "R5 clear suppresses expiry", tmo_irq, 0);
        repeat (15) @(negedge clk);
        check(tmo_irq == 1'b0, "R5 no early pulse after clear", tmo_irq, 0);
        @(negedge clk);
        check(tmo_irq == 1'b1, "R5 pulse one period after clear", tmo_irq, 1);

        // Vector table walk
        do_reset();
        for (int v = 0; v < NVEC; v++) begin
            logic [17:0] e;
            e = VEC[v];
            wr(e[17], e[16:9]);
            check(mode_rdata == e[8:1], $sformatf("R2 R10 mode vec %0d", v), mode_rdata, e[8:1]);
            t_seen = 0;
            r_seen = 0;
            win = per_len(e[3:2]) + 2;
            for (int c = 0; c < win; c++) begin
                @(negedge clk);
                if (tmo_irq) t_seen++;
                if (rst_req) r_seen++;
            end
            if (e[0])
                check(t_seen >= 1, $sformatf("R6 R8 running vec %0d", v), t_seen, 1);
            else
                check(t_seen == 0, $sformatf("R9 stopped vec %0d", v), t_seen, 0);
            check(r_seen == (e[4] ? t_seen : 0), $sformatf("R4 reset pulses vec %0d", v),
                  r_seen, e[4] ? t_seen : 0);
        end

        // R3: longest period, 1024 with bench parameters
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h4E);
        wr(1'b1, 8'hB1);
        wr(1'b0, 8'h07);
        check(mode_rdata == 8'h07, "R10 period 11 taken", mode_rdata, 8'h07);
        k = 0;
        while (k < 3000) begin
            k++;
            @(negedge clk);
            if (tmo_irq) break;
        end
        check(k == 1024, "R8 first pulse after restart", k, 1024);
        k = 0;
        while (k < 3000) begin
            k++;
            @(negedge clk);
            if (tmo_irq) break;
        end
        check(k == 1024, "R3 period 11 interval", k, 1024);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule